// File: doc/BRIEF.md
# Deep sleep oscillator gating controller

This controller runs on a free-running oscillator clock and decides when the oscillator's output may be switched off. A processor raises a sleep request from its own clock domain, which is asynchronous to the oscillator. The controller synchronises that request and starts a delay counter on its rising edge. When the count equals a programmed delay, the controller sets a completion flag. A mode bit chosen at entry time then selects one of two paths. The standby path keeps the oscillator running. The deep path drops the oscillator clock enable on the same edge that the flag sets.

An external wake pin, also synchronised, ends either sleep state. It clears the completion flag and the counter and raises the clock enable again. If the request is lost while the delay is being counted, a timeout timer sets a separate status bit and returns the controller to the run state, so software polling the flag never waits forever. The timer's limit is the programmed delay plus a fixed margin.

Software sees two 32-bit registers on a simple synchronous register port. The control register holds the mode select and the delay. The status register holds the completion, timeout, asleep and gated bits.

Top module: `dsg_ctrl`

## Requirements
- R1: After reset, osc_en_o is 1 and asleep_o is 0. The status register reads 0. The control register reads with mode bit 0 (standby) and the delay field equal to DLY_RST.
- R2: The control register is at offset 0x324: bit 0 is the deep mode select (1 = deep), bits [CNT_W:1] are the delay D. The status register is at offset 0x328 and is read-only: bit 0 done, bit 1 timeout, bit 2 asleep, bit 3 gated. Writes to the status offset have no effect, and any other offset reads 0.
- R3: The request is passed through a two-stage synchroniser. If sleep_req_i rises between clock edges and stays high, done becomes 1 on the (D+4)th rising edge after the rise and not before; D = 0 is legal.
- R4: With mode bit 0, completion sets done and asleep, while osc_en_o stays 1 and gated stays 0.
- R5: With mode bit 1, osc_en_o falls to 0 and gated rises to 1 on the same edge that done becomes 1.
- R6: In either sleep state, wake_i held high brings osc_en_o back to 1 and clears done and asleep on the third rising edge after wake_i rises. wake_i has no effect in the run state.
- R7: If the synchronised request falls before completion, the delay counter pauses. The timeout timer still runs, and on the (D+MARGIN+4)th edge after the request rose it sets the timeout bit. done stays 0, the controller returns to run with osc_en_o at 1, and the timeout bit clears when the next entry starts.
- R8: The mode bit and delay are captured when an entry starts. Control writes made during counting do not change that entry's timing or path.
- R9: A new entry starts only on a fresh rising edge of the synchronised request. A request still high after wake-up starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| sleep_req_i | input | 1 | Sleep request from an asynchronous domain |
| wake_i | input | 1 | External wake pin, asynchronous |
| osc_en_o | output | 1 | Oscillator clock enable, 0 while gated |
| asleep_o | output | 1 | High in either sleep state |

## Verification
The bench builds the block with CNT_W = 16, MARGIN = 8 and DLY_RST = 16. With these values, delays from 0 up to about 20 can be counted edge by edge, and the timeout of D+8 cycles stays short. A small table walks both modes through several delays, including D = 0. Directed tests then cover the lost-request timeout and its clearing, and a mid-count rewrite of the control register. Further tests show that a held request does not re-trigger, that a wake in the run state does nothing, and that the status register rejects writes.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

  typedef enum logic [1:0] {
    S_RUN  = 2'd0,
    S_CNT  = 2'd1,
    S_STBY = 2'd2,
    S_DEEP = 2'd3
  } dsg_state_e;

  // timeout limit: captured delay plus fixed margin, one bit wider
  function automatic logic [32:0] tmo_limit(input logic [31:0] dly,
                                            input logic [31:0] margin);
    return {1'b0, dly} + {1'b0, margin};
  endfunction

  function automatic logic rise(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/dsg_sync.sv
module dsg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/dsg_regs.sv
module dsg_regs #(
  parameter int                     ADDR_W   = 12,
  parameter int                     CNT_W    = 16,
  parameter logic [ADDR_W-1:0]      CTRL_OFS = 12'h324,
  parameter logic [ADDR_W-1:0]      STAT_OFS = 12'h328,
  parameter logic [CNT_W-1:0]       DLY_RST  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              st_done,
  input  logic              st_tmo,
  input  logic              st_asleep,
  input  logic              st_gated,
  output logic              deep_sel,
  output logic [CNT_W-1:0]  delay
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[31:CNT_W+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deep_sel <= 1'b0;
      delay    <= DLY_RST;
    end else if (we && addr == CTRL_OFS) begin
      deep_sel <= wdata[0];
      delay    <= wdata[CNT_W:1];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_OFS)      rdata = 32'({delay, deep_sel});
    else if (addr == STAT_OFS) rdata = 32'({st_gated, st_asleep, st_tmo, st_done});
  end
endmodule

// File: rtl/dsg_seq.sv
module dsg_seq
  import dsg_pkg::*;
#(
  parameter int               CNT_W  = 16,
  parameter logic [CNT_W-1:0] MARGIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_s,
  input  logic             wake_s,
  input  logic             deep_sel,
  input  logic [CNT_W-1:0] delay,
  output logic             osc_en,
  output logic             done,
  output logic             tmo,
  output logic             asleep,
  output logic             gated,
  output logic             counting,
  output logic             tmo_fire
);
  localparam int TW = CNT_W + 1;

  dsg_state_e       state;
  logic             req_p;
  logic [CNT_W-1:0] cnt;
  logic [TW-1:0]    tq;
  logic [CNT_W-1:0] dly_q;
  logic             mode_q;
  logic [TW-1:0]    lim;
  logic             start, hit;

  assign lim      = TW'(tmo_limit(32'(dly_q), 32'(MARGIN)));
  assign start    = (state == S_RUN) && rise(req_s, req_p);
  assign counting = (state == S_CNT);
  assign hit      = counting && (cnt == dly_q);
  assign tmo_fire = counting && !hit && (tq == lim);
  assign asleep   = (state == S_STBY) || (state == S_DEEP);
  assign gated    = (state == S_DEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_RUN;
      req_p  <= 1'b0;
      cnt    <= '0;
      tq     <= '0;
      dly_q  <= '0;
      mode_q <= 1'b0;
      done   <= 1'b0;
      tmo    <= 1'b0;
      osc_en <= 1'b1;
    end else begin
      req_p <= req_s;
      unique case (state)
        S_RUN: begin
          if (start) begin
            state  <= S_CNT;
            cnt    <= '0;
            tq     <= '0;
            dly_q  <= delay;
            mode_q <= deep_sel;
            tmo    <= 1'b0;
          end
        end
        S_CNT: begin
          tq <= tq + 1'b1;
          if (hit) begin
            done   <= 1'b1;
            state  <= mode_q ? S_DEEP : S_STBY;
            osc_en <= ~mode_q;
          end else if (tmo_fire) begin
            tmo   <= 1'b1;
            state <= S_RUN;
          end else if (req_s) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STBY, S_DEEP: begin
          if (wake_s) begin
            done   <= 1'b0;
            cnt    <= '0;
            tq     <= '0;
            osc_en <= 1'b1;
            state  <= S_RUN;
          end
        end
        default: state <= S_RUN;
      endcase
    end
  end
endmodule

// File: rtl/dsg_ctrl.sv
module dsg_ctrl #(
  parameter int                ADDR_W   = 12,
  parameter int                CNT_W    = 16,
  parameter int                SYNC_N   = 2,
  parameter logic [CNT_W-1:0]  MARGIN   = 8,
  parameter logic [CNT_W-1:0]  DLY_RST  = 16,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h324,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h328
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              sleep_req_i,
  input  logic              wake_i,
  output logic              osc_en_o,
  output logic              asleep_o
);
  logic             req_s_w, wake_s_w;
  logic             deep_sel_w;
  logic [CNT_W-1:0] delay_w;
  logic             done_w, tmo_w, asleep_w, gated_w, counting_w, tmo_fire_w;

  dsg_sync #(.STAGES(SYNC_N)) u_req_sync (
    .clk(osc_clk), .rst_n(rst_n), .d(sleep_req_i), .q(req_s_w));

  dsg_sync #(.STAGES(SYNC_N)) u_wake_sync (
    .clk(osc_clk), .rst_n(rst_n), .d(wake_i), .q(wake_s_w));

  dsg_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CTRL_OFS(CTRL_OFS),
    .STAT_OFS(STAT_OFS), .DLY_RST(DLY_RST)
  ) u_regs (
    .clk(osc_clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .st_done(done_w), .st_tmo(tmo_w),
    .st_asleep(asleep_w), .st_gated(gated_w), .deep_sel(deep_sel_w),
    .delay(delay_w));

  dsg_seq #(.CNT_W(CNT_W), .MARGIN(MARGIN)) u_seq (
    .clk(osc_clk), .rst_n(rst_n), .req_s(req_s_w), .wake_s(wake_s_w),
    .deep_sel(deep_sel_w), .delay(delay_w), .osc_en(osc_en_o),
    .done(done_w), .tmo(tmo_w), .asleep(asleep_w), .gated(gated_w),
    .counting(counting_w), .tmo_fire(tmo_fire_w));

  assign asleep_o = asleep_w;
endmodule

// File: rtl/dsg_ctrl_chk.sv
module dsg_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_en,
  input logic done,
  input logic tmo,
  input logic asleep,
  input logic gated,
  input logic counting,
  input logic wake_s,
  input logic tmo_fire
);
  // R5
  gate_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (done && gated));

  // R4
  stby_keeps_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !gated) |-> osc_en);

  // R3
  done_from_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(counting));

  // R7
  tmo_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> (!counting && !asleep && osc_en && tmo && !done));

  // R6
  wake_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && wake_s) |=> (osc_en && !asleep && !done));
endmodule

bind dsg_ctrl dsg_ctrl_chk u_chk (
  .clk(osc_clk), .rst_n(rst_n), .osc_en(osc_en_o), .done(done_w),
  .tmo(tmo_w), .asleep(asleep_w), .gated(gated_w), .counting(counting_w),
  .wake_s(wake_s_w), .tmo_fire(tmo_fire_w));

// File: tb/tb_dsg_ctrl.sv
module tb_dsg_ctrl;
  localparam logic [11:0] CTRL = 12'h324;
  localparam logic [11:0] STAT = 12'h328;
  localparam int          MRG  = 8;

  // {deep, delay}
  localparam logic [16:0] VEC [5] = '{
    {1'b0, 16'd0}, {1'b0, 16'd5}, {1'b1, 16'd3}, {1'b1, 16'd12}, {1'b1, 16'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req = 1'b0, wake = 1'b0;
  logic        osc_en, asleep;
  int          total = 0, bad = 0;
  logic        finished = 1'b0;

  always #5 clk = ~clk;

  dsg_ctrl #(.ADDR_W(12), .CNT_W(16), .SYNC_N(2), .MARGIN(16'd8),
             .DLY_RST(16'd16)) dut (
    .osc_clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req_i(req),
    .wake_i(wake), .osc_en_o(osc_en), .asleep_o(asleep));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input logic deep, input logic [15:0] d);
    return 32'({d, deep});
  endfunction

  task automatic wake_up();
    logic [31:0] s;
    wake = 1'b1;
    tick(2);
    chk("R6 still asleep two edges after wake", 32'(asleep), 32'd1);
    tick(1);
    chk("R6 osc_en after wake", 32'(osc_en), 32'd1);
    chk("R6 asleep after wake", 32'(asleep), 32'd0);
    rd(STAT, s);
    chk("R6 done cleared by wake", 32'(s[0]), 32'd0);
    wake = 1'b0;
    tick(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    chk("R1 osc_en", 32'(osc_en), 32'd1);
    chk("R1 asleep", 32'(asleep), 32'd0);
    rd(STAT, s); chk("R1 status", s, 32'd0);
    rd(CTRL, s); chk("R1 ctrl", s, ctrl_word(1'b0, 16'd16));

    // R2 map
    wr(CTRL, ctrl_word(1'b1, 16'hABCD));
    rd(CTRL, s); chk("R2 ctrl readback", s, 32'h0001579B);
    wr(STAT, 32'hFFFF_FFFF);
    rd(STAT, s); chk("R2 status read-only", s, 32'd0);
    rd(12'h000, s); chk("R2 other offset", s, 32'd0);

    // R6 wake in run state ignored
    wake = 1'b1; tick(5);
    chk("R6 run wake osc_en", 32'(osc_en), 32'd1);
    chk("R6 run wake asleep", 32'(asleep), 32'd0);
    wake = 1'b0; tick(4);

    // table walk: R3 timing, R4/R5 path
    foreach (VEC[i]) begin
      logic        dp = VEC[i][16];
      logic [15:0] d  = VEC[i][15:0];
      wr(CTRL, ctrl_word(dp, d));
      req = 1'b1;
      tick(int'(d) + 3);
      rd(STAT, s); chk("R3 done not early", 32'(s[0]), 32'd0);
      tick(1);
      rd(STAT, s);
      chk("R3 done on edge D+4", 32'(s[0]), 32'd1);
      chk("R4 asleep bit", 32'(s[2]), 32'd1);
      chk("R5 gated bit", 32'(s[3]), 32'(dp));
      chk(dp ? "R5 osc gated" : "R4 osc running", 32'(osc_en), 32'(!dp));
      req = 1'b0;
      wake_up();
    end

    // R7 lost request -> timeout
    wr(CTRL, ctrl_word(1'b1, 16'd10));
    req = 1'b1; tick(3);
    req = 1'b0;
    tick(10 + MRG + 4 - 3 - 1);
    rd(STAT, s); chk("R7 timeout not early", 32'(s[1]), 32'd0);
    tick(1);
    rd(STAT, s);
    chk("R7 timeout set", 32'(s[1]), 32'd1);
    chk("R7 done stays 0", 32'(s[0]), 32'd0);
    chk("R7 back to run", 32'(asleep), 32'd0);
    chk("R7 osc running", 32'(osc_en), 32'd1);
    req = 1'b1; tick(3);
    rd(STAT, s); chk("R7 timeout cleared on new entry", 32'(s[1]), 32'd0);
    tick(20);
    rd(STAT, s); chk("R7 later entry completes", 32'(s[0]), 32'd1);
    req = 1'b0;
    wake_up();

    // R8 mid-count rewrite ignored by current entry
    wr(CTRL, ctrl_word(1'b0, 16'd6));
    req = 1'b1; tick(4);
    wr(CTRL, ctrl_word(1'b1, 16'd20));
    tick(4);
    rd(STAT, s); chk("R8 done not early", 32'(s[0]), 32'd0);
    tick(1);
    rd(STAT, s);
    chk("R8 done at captured delay", 32'(s[0]), 32'd1);
    chk("R8 captured standby path", 32'(osc_en), 32'd1);
    chk("R8 not gated", 32'(s[3]), 32'd0);

    // R9 held request does not re-trigger after wake
    wake_up();
    tick(30);
    rd(STAT, s);
    chk("R9 no new entry done", 32'(s[0]), 32'd0);
    chk("R9 no new entry asleep", 32'(asleep), 32'd0);
    req = 1'b0; tick(4);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule